// File: doc/BRIEF.md
# Card-Side Plug-and-Play Configuration Controller

This block is the card end of an index/data style plug-and-play configuration interface on a legacy I/O bus. The host writes a register index to a fixed index port and then writes data to a fixed write-data port. It reads results back from a read port whose address the host itself programs. The card moves through four states: waiting for the initiation key, asleep, isolating, and configurable. It holds a card select number (CSN) and a selected logical device number.

The key detection sequence is reduced to one `key_ok` input. A wake command compares its data with the CSN. A match sends a sleeping card to isolation when the data is zero, and to the configurable state when it is not. A match also rewinds the pointer into a small resource-description ROM. A mismatch sends an active card back to sleep. The control register is write-only and self-clearing. It can pulse a logical-device reset, clear the CSN, or return the card to the key-wait state.

Top module: `pnpcfg_ctrl`

## Requirements
- R1: After reset the state is WaitKey (code 0), `csn_o` and `ldn_o` are 0, `io_rack` is 0 and `dev_rst` is 0. The state codes are WaitKey=0, Sleep=1, Isolation=2, Config=3.
- R2: In WaitKey every port write is ignored. A `key_ok` pulse in WaitKey moves the card to Sleep on the next clock.
- R3: A write of data D to index 0x03 (wake) behaves as follows. With D equal to the CSN, a card in Sleep goes to Isolation if D is 0 and to Config otherwise, and a card in Isolation or Config stays put. With D not equal to the CSN, a card in Isolation or Config goes to Sleep and a card in Sleep stays in Sleep.
- R4: A write to index 0x02 acts on its data bits and stores nothing. Bit 0 gives a one-cycle `dev_rst` pulse and keeps the CSN. Bit 1 returns the card to WaitKey and keeps the CSN. Bit 2 clears the CSN to 0.
- R5: Writes to index 0x00 and 0x07 take effect only in Config. Writes to index 0x06 take effect only in Isolation or Config. In Sleep only the wake and control writes act.
- R6: Writing V to index 0x00 sets the read-port address to {6'b0, V, 2'b11}. A read at any other address is ignored. A read at that address is answered only in Config, with `io_rack` high and `io_rdata` valid one clock after the read.
- R7: Index 0x06 holds the CSN and can be both written and read back.
- R8: Index 0x07 holds the logical device number. With NUM_LDN greater than 1, a write below NUM_LDN is stored and larger values are ignored. With NUM_LDN equal to 1, it reads 0x00 and ignores all writes.
- R9: A read of index 0x04 returns ROM byte k = (29*k + 90) mod 256 and advances the pointer, which wraps after ROM_DEPTH bytes. Index 0x05 returns the ready flag in bit 0, with the other bits 0. The flag is low for one cycle after each resource read.
- R10: A wake write whose data matches the CSN returns the resource pointer to byte 0, and the ready flag is low in the cycle that follows.
- R11: Reads of indices other than 0x04 to 0x07, including 0x00 and 0x02, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_ok | input | 1 | Initiation key accepted (pulse) |
| io_wr | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host write I/O address |
| wr_data | input | 8 | Host write data |
| io_rd | input | 1 | Host read strobe |
| rd_addr | input | 16 | Host read I/O address |
| io_rdata | output | 8 | Registered read data |
| io_rack | output | 1 | Card answered the previous read |
| card_state | output | 2 | Card state code |
| csn_o | output | 8 | Card select number |
| ldn_o | output | 8 | Selected logical device |
| dev_rst | output | 1 | Logical-device reset pulse |

## Verification
A CSN write on the data port and a CSN read on the read port can fall in the same clock, because both act on the index 0x06 that is currently selected. The bench drives both strobes in one cycle. It expects the read to return the CSN from before the write, `csn_o` to show the new value on the next cycle, and a second read to return that new value. The bench also runs a second instance built with one logical device on the same bus, to check that index 0x07 stays 0 there.

// File: rtl/pnpcfg_pkg.sv
package pnpcfg_pkg;
  typedef enum logic [1:0] {
    ST_WAITKEY = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_ISOL    = 2'd2,
    ST_CONFIG  = 2'd3
  } card_st_t;

  localparam logic [7:0] IX_RDPORT = 8'h00;
  localparam logic [7:0] IX_CTL    = 8'h02;
  localparam logic [7:0] IX_WAKE   = 8'h03;
  localparam logic [7:0] IX_RES    = 8'h04;
  localparam logic [7:0] IX_STAT   = 8'h05;
  localparam logic [7:0] IX_CSN    = 8'h06;
  localparam logic [7:0] IX_LDN    = 8'h07;
endpackage

// File: rtl/pnpcfg_fsm.sv
module pnpcfg_fsm
  import pnpcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_ok,
  input  logic       wake_we,
  input  logic       ctl_we,
  input  logic       csn_we,
  input  logic [7:0] wdata,
  output card_st_t   state,
  output logic [7:0] csn,
  output logic       dev_rst,
  output logic       wake_hit
);
  logic csn_match;
  assign csn_match = (wdata == csn);
  assign wake_hit  = wake_we && csn_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_WAITKEY;
      csn     <= 8'h00;
      dev_rst <= 1'b0;
    end else begin
      dev_rst <= ctl_we && wdata[0];
      if (ctl_we && wdata[2])
        csn <= 8'h00;
      else if (csn_we)
        csn <= wdata;
      if (state == ST_WAITKEY) begin
        if (key_ok) state <= ST_SLEEP;
      end else if (ctl_we && wdata[1]) begin
        state <= ST_WAITKEY;
      end else if (wake_we) begin
        if (csn_match) begin
          if (state == ST_SLEEP)
            state <= (wdata == 8'h00) ? ST_ISOL : ST_CONFIG;
        end else if (state != ST_SLEEP) begin
          state <= ST_SLEEP;
        end
      end
    end
  end
endmodule

// File: rtl/pnpcfg_resrc.sv
module pnpcfg_resrc #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rewind,
  input  logic       advance,
  output logic [7:0] res_q,
  output logic       ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr;

  function automatic logic [7:0] rom_byte(input logic [PW-1:0] k);
    return 8'((32'(k) * 29 + 90) % 256);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      ready <= 1'b0;
      res_q <= 8'h00;
    end else begin
      res_q <= rom_byte(ptr);
      ready <= !(rewind || advance);
      if (rewind)
        ptr <= '0;
      else if (advance)
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pnpcfg_ctrl.sv
module pnpcfg_ctrl
  import pnpcfg_pkg::*;
#(
  parameter bit ALT_MAP   = 1'b0,
  parameter int NUM_LDN   = 4,
  parameter int ROM_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        key_ok,
  input  logic        io_wr,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        io_rd,
  input  logic [15:0] rd_addr,
  output logic [7:0]  io_rdata,
  output logic        io_rack,
  output logic [1:0]  card_state,
  output logic [7:0]  csn_o,
  output logic [7:0]  ldn_o,
  output logic        dev_rst
);
  localparam logic [15:0] PORT_IDX = ALT_MAP ? 16'h0259 : 16'h0279;
  localparam logic [15:0] PORT_WD  = ALT_MAP ? 16'h0A59 : 16'h0A79;

  card_st_t   state;
  logic [7:0] idx, rdsel, csn, ldn, res_q;
  logic       awake, in_cfg, in_iso, idx_we, dat_we, rd_hit;
  logic       wake_we, ctl_we, csn_we, ldn_we, rdsel_we, res_rd;
  logic       wake_hit, res_ready;

  assign awake    = (state != ST_WAITKEY);
  assign in_cfg   = (state == ST_CONFIG);
  assign in_iso   = (state == ST_ISOL);
  assign idx_we   = io_wr && awake && (wr_addr == PORT_IDX);
  assign dat_we   = io_wr && awake && (wr_addr == PORT_WD);
  assign rd_hit   = io_rd && in_cfg && (rd_addr == {6'b0, rdsel, 2'b11});
  assign wake_we  = dat_we && (idx == IX_WAKE);
  assign ctl_we   = dat_we && (idx == IX_CTL);
  assign csn_we   = dat_we && (idx == IX_CSN) && (in_cfg || in_iso);
  assign ldn_we   = dat_we && (idx == IX_LDN) && in_cfg;
  assign rdsel_we = dat_we && (idx == IX_RDPORT) && in_cfg;
  assign res_rd   = rd_hit && (idx == IX_RES);

  pnpcfg_fsm u_fsm (
    .clk(clk), .rst(rst), .key_ok(key_ok), .wake_we(wake_we),
    .ctl_we(ctl_we), .csn_we(csn_we), .wdata(wr_data),
    .state(state), .csn(csn), .dev_rst(dev_rst), .wake_hit(wake_hit)
  );

  pnpcfg_resrc #(.DEPTH(ROM_DEPTH)) u_res (
    .clk(clk), .rst(rst), .rewind(wake_hit), .advance(res_rd),
    .res_q(res_q), .ready(res_ready)
  );

  generate
    if (NUM_LDN > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)
          ldn <= 8'h00;
        else if (ldn_we && (32'(wr_data) < NUM_LDN))
          ldn <= wr_data;
      end
    end else begin : g_single
      assign ldn = 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= 8'h00;
      rdsel    <= 8'h00;
      io_rdata <= 8'h00;
      io_rack  <= 1'b0;
    end else begin
      if (idx_we)   idx   <= wr_data;
      if (rdsel_we) rdsel <= wr_data;
      io_rack <= rd_hit;
      if (rd_hit) begin
        case (idx)
          IX_RES:  io_rdata <= res_q;
          IX_STAT: io_rdata <= {7'b0, res_ready};
          IX_CSN:  io_rdata <= csn;
          IX_LDN:  io_rdata <= ldn;
          default: io_rdata <= 8'h00;
        endcase
      end
    end
  end

  assign card_state = state;
  assign csn_o      = csn;
  assign ldn_o      = ldn;
endmodule

// File: rtl/pnpcfg_chk.sv
module pnpcfg_chk (
  input logic       clk,
  input logic       rst,
  input logic       key_ok,
  input logic       io_rd,
  input logic       io_rack,
  input logic [1:0] card_state,
  input logic       dev_rst,
  input logic       res_rd,
  input logic       res_ready,
  input logic       wake_hit
);
  // R2
  key_to_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (card_state == 2'd0 && key_ok) |=> card_state == 2'd1);

  // R2
  waitkey_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (card_state == 2'd0) |=> (card_state == 2'd0 || card_state == 2'd1));

  // R4
  dev_rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dev_rst |=> !dev_rst);

  // R6
  rack_source_chk: assert property (@(posedge clk) disable iff (rst)
    io_rack |-> ($past(io_rd) && $past(card_state) == 2'd3));

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    res_rd |=> !res_ready);

  // R10
  rewind_ready_chk: assert property (@(posedge clk) disable iff (rst)
    wake_hit |=> !res_ready);
endmodule

bind pnpcfg_ctrl pnpcfg_chk u_chk (
  .clk(clk), .rst(rst), .key_ok(key_ok), .io_rd(io_rd), .io_rack(io_rack),
  .card_state(card_state), .dev_rst(dev_rst), .res_rd(res_rd),
  .res_ready(res_ready), .wake_hit(wake_hit)
);

// File: tb/pnpcfg_ctrl_test.sv
module pnpcfg_ctrl_test;
  localparam int DEPTH = 16;
  localparam logic [15:0] PIDX = 16'h0279;
  localparam logic [15:0] PWD  = 16'h0A79;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_ok = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rdata, csn, ldn, rdata1, csn1, ldn1;
  logic rack, drst, rack1, drst1;
  logic [1:0] st, st1;
  logic [15:0] rport;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pnpcfg_ctrl uut (
    .clk(clk), .rst(rst), .key_ok(key_ok), .io_wr(io_wr), .wr_addr(wr_addr),
    .wr_data(wr_data), .io_rd(io_rd), .rd_addr(rd_addr), .io_rdata(rdata),
    .io_rack(rack), .card_state(st), .csn_o(csn), .ldn_o(ldn), .dev_rst(drst)
  );

  pnpcfg_ctrl #(.NUM_LDN(1)) uut_one (
    .clk(clk), .rst(rst), .key_ok(key_ok), .io_wr(io_wr), .wr_addr(wr_addr),
    .wr_data(wr_data), .io_rd(io_rd), .rd_addr(rd_addr), .io_rdata(rdata1),
    .io_rack(rack1), .card_state(st1), .csn_o(csn1), .ldn_o(ldn1), .dev_rst(drst1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] ix, input logic [7:0] d);
    wr(PIDX, ix);
    wr(PWD, d);
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); io_rd = 1'b1; rd_addr = a;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk(st == 2'd0 && csn == 8'h00 && ldn == 8'h00, "R1 state/csn/ldn", {st, csn, ldn}, 0);
    chk(rack == 1'b0 && drst == 1'b0, "R1 rack/dev_rst", {rack, drst}, 0);
  endtask

  task automatic t_waitkey;
    setreg(8'h06, 8'h44);
    chk(csn == 8'h00, "R2 write ignored in WaitKey", csn, 0);
    @(negedge clk); key_ok = 1'b1;
    @(negedge clk); key_ok = 1'b0;
    chk(st == 2'd1, "R2 key to Sleep", st, 1);
  endtask

  task automatic t_sleep;
    setreg(8'h06, 8'h33);
    chk(csn == 8'h00, "R5 csn write ignored in Sleep", csn, 0);
    setreg(8'h03, 8'h05);
    chk(st == 2'd1, "R3 mismatch in Sleep stays", st, 1);
    wr(PWD, 8'h00);
    chk(st == 2'd2, "R3 wake 0 to Isolation", st, 2);
    setreg(8'h00, 8'h20);
    setreg(8'h06, 8'h05);
    chk(csn == 8'h05, "R7 csn write in Isolation", csn, 5);
    setreg(8'h03, 8'h00);
    chk(st == 2'd1, "R3 mismatch Isolation to Sleep", st, 1);
    wr(PWD, 8'h05);
    chk(st == 2'd3, "R3 wake nonzero to Config", st, 3);
    wr(PWD, 8'h05);
    chk(st == 2'd3, "R3 match in Config stays", st, 3);
  endtask

  task automatic t_readport;
    setreg(8'h06, 8'h05);
    rd(16'h0003);
    chk(rack == 1'b1 && rdata == 8'h05, "R5 R6 read at initial port", {rack, rdata}, 9'h105);
    setreg(8'h00, 8'h20);
    rport = 16'h0083;
    rd(16'h0003);
    chk(rack == 1'b0, "R6 old port ignored", rack, 0);
    wr(PIDX, 8'h06);
    rd(rport);
    chk(rack == 1'b1 && rdata == 8'h05, "R6 R7 csn readback", {rack, rdata}, 9'h105);
    wr(PIDX, 8'h02);
    rd(rport);
    chk(rdata == 8'h00, "R11 index 0x02 reads 0", rdata, 0);
    wr(PIDX, 8'h00);
    rd(rport);
    chk(rdata == 8'h00, "R11 index 0x00 reads 0", rdata, 0);
  endtask

  task automatic t_same_cycle;
    wr(PIDX, 8'h06);
    @(negedge clk);
    io_wr = 1'b1; wr_addr = PWD; wr_data = 8'h09;
    io_rd = 1'b1; rd_addr = rport;
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
    chk(rdata == 8'h05, "R7 same-cycle read sees old csn", rdata, 5);
    chk(csn == 8'h09, "R7 csn updated", csn, 9);
    rd(rport);
    chk(rdata == 8'h09, "R7 next read sees new csn", rdata, 9);
  endtask

  task automatic t_ldn;
    setreg(8'h07, 8'h02);
    chk(ldn == 8'h02, "R8 ldn write", ldn, 2);
    wr(PWD, 8'h07);
    chk(ldn == 8'h02, "R8 out-of-range ldn ignored", ldn, 2);
    rd(rport);
    chk(rdata == 8'h02, "R8 ldn readback", rdata, 2);
    chk(ldn1 == 8'h00 && rack1 == 1'b1 && rdata1 == 8'h00, "R8 single-device reads 0",
        {ldn1, rack1, rdata1}, 9'h100);
  endtask

  task automatic t_resource;
    setreg(8'h03, 8'h09);
    wr(PIDX, 8'h04);
    for (int k = 0; k < DEPTH + 2; k++) begin
      rd(rport);
      chk(rdata == 8'(((k % DEPTH) * 29 + 90) % 256), "R9 resource byte", rdata,
          ((k % DEPTH) * 29 + 90) % 256);
    end
    wr(PIDX, 8'h05);
    rd(rport);
    chk(rdata == 8'h01, "R9 status ready", rdata, 1);
    setreg(8'h03, 8'h09);
    wr(PIDX, 8'h04);
    rd(rport);
    chk(rdata == 8'd90, "R10 wake rewinds pointer", rdata, 90);
  endtask

  task automatic t_ctl;
    setreg(8'h02, 8'h01);
    chk(drst == 1'b1 && st == 2'd3 && csn == 8'h09, "R4 dev reset pulse", {drst, st, csn}, 11'h709);
    @(negedge clk);
    chk(drst == 1'b0, "R4 dev reset self-clears", drst, 0);
    wr(PWD, 8'h04);
    chk(csn == 8'h00 && st == 2'd3, "R4 csn clear", {st, csn}, 10'h300);
    wr(PWD, 8'h02);
    chk(st == 2'd0, "R4 return to WaitKey", st, 0);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_waitkey();
    t_sleep();
    t_readport();
    t_same_cycle();
    t_ldn();
    t_resource();
    t_ctl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule